// File: doc/BRIEF.md
# Serial 4/5-Bit Prefix Letter Codec

This block turns a one-bit-per-cycle stream into letter indices (0 for a through 25 for z). The stream uses a prefix-free code with 4-bit and 5-bit codewords. The third bit received settles how long the current codeword is. A codeword beginning with 1 is long, and so is one beginning with 000; every other codeword is short. Across the alphabet this costs 124 bits, where a flat 5-bit code costs 130.

The decoder counts bits and shifts them into a small register. When the last bit of a codeword is accepted, it raises a one-cycle pulse with the decoded index and returns to its starting state. Codewords can therefore follow one another with no idle cycles between them. The code has no spare pattern to resynchronise on, so the decoder must begin at a codeword boundary, which a synchronous reset provides.

An encoder sits beside the decoder. It takes a letter index and sends that letter's codeword MSB first. It can take the next index while it is sending the last bit of the current one, so a string of letters leaves as one unbroken bit stream.

Top module: `pfx_codec`

## Requirements
- R1: The synchronous reset clears `letter_vld` and `ser_vld`, raises `sym_ready`, and returns the decoder to the codeword-start state, even when a codeword was only partly received.
- R2: The short codewords 0010, 0011, 0100, 0101, 0110 and 0111 decode to indices 0 to 5 in that order.
- R3: The long codewords 10000 through 11111 decode to indices 6 to 21 in ascending order.
- R4: The long codewords 00000, 00001, 00010 and 00011 decode to indices 22 to 25 in that order.
- R5: `letter_vld` is high for exactly one cycle, the one after the clock edge that accepts a codeword's final bit. Back-to-back codewords decode with no gap between them.
- R6: A cycle with `bit_vld` low leaves the decoder state unchanged, whatever `bit_in` carries, and produces no pulse.
- R7: After index i is accepted, `ser_out` carries that letter's codeword MSB first. `ser_vld` stays high for exactly the codeword length (4 or 5 cycles).
- R8: `sym_ready` is high when the encoder is idle or sending its last bit. A load accepted on the last bit makes the next codeword follow with no gap, so all 26 letters in a row take exactly 124 consecutive `ser_vld` cycles.
- R9: A load with an index of 26 to 31 is ignored: the encoder sends no bits and `ser_vld` stays low.
- R10: Whenever `letter_vld` is high, `letter_out` is at most 25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial code bit, MSB of each codeword first |
| bit_vld | input | 1 | `bit_in` is taken on this cycle |
| letter_out | output | 5 | Decoded letter index |
| letter_vld | output | 1 | One-cycle pulse when a codeword completes |
| sym_in | input | 5 | Letter index to encode |
| sym_load | input | 1 | Request to load `sym_in` |
| sym_ready | output | 1 | Encoder will accept a load on this cycle |
| ser_out | output | 1 | Encoded serial bit |
| ser_vld | output | 1 | `ser_out` carries a code bit |

## Verification
The decoder assertions assume the stream starts at a codeword boundary after reset. They also assume `bit_in` matters only when `bit_vld` is high. The stimulus therefore sends only whole codewords after each reset, except for one deliberately partial codeword that a reset then cuts off, and during stall cycles it toggles `bit_in` as junk. The encoder assertions allow `sym_load` at any time with any index. The bench drives a load only when `sym_ready` is seen high, except in the out-of-range case, where the encoder is idle.

// File: rtl/pfx_codec_pkg.sv
package pfx_codec_pkg;

   localparam int SYM_W     = 5;   // letter index width
   localparam int CW_W      = 5;   // longest codeword
   localparam int CW_SHORT  = 4;   // shortest codeword
   localparam int LETTERS   = 26;
   localparam int N_SHORT   = 6;   // indices 0..5 are short
   localparam int N_HIGH    = 16;  // indices 6..21 start with 1

   typedef struct packed {
      logic [CW_W-1:0] bits;   // right-aligned codeword
      logic            long_cw;
   } cw_t;

   // Codeword for a letter index (index assumed in range)
   function automatic cw_t cw_of(input logic [SYM_W-1:0] idx);
      cw_t r;
      if (idx < SYM_W'(N_SHORT)) begin
         r.bits    = idx + CW_W'(2);
         r.long_cw = 1'b0;
      end else if (idx < SYM_W'(N_SHORT + N_HIGH)) begin
         r.bits    = idx + CW_W'(10);
         r.long_cw = 1'b1;
      end else begin
         r.bits    = idx - CW_W'(N_SHORT + N_HIGH);
         r.long_cw = 1'b1;
      end
      return r;
   endfunction

endpackage

// File: rtl/pfx_len_sel.sv
module pfx_len_sel (
   input  logic [2:0] head,      // first three bits, oldest in [2]
   output logic       is_long
);
   always_comb is_long = head[2] | (head == 3'b000);
endmodule

// File: rtl/pfx_serial_dec.sv
module pfx_serial_dec
   import pfx_codec_pkg::*;
#(
   parameter int IDX_W = SYM_W,
   parameter int SH_W  = CW_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bit_in,
   input  logic             bit_vld,
   output logic [IDX_W-1:0] idx_out,
   output logic             idx_vld
);
   localparam int CNT_W = $clog2(SH_W + 1);
   localparam logic [CNT_W-1:0] CNT_HEAD  = CNT_W'(2);
   localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(CW_SHORT - 1);
   localparam logic [CNT_W-1:0] CNT_LONG  = CNT_W'(SH_W - 1);

   logic [SH_W-1:0]  sh_q, sh_nx;
   logic [CNT_W-1:0] cnt_q;
   logic             long_q, long_now, last_bit;
   logic [IDX_W-1:0] idx_nx;

   assign sh_nx = {sh_q[SH_W-2:0], bit_in};

   pfx_len_sel u_len (.head(sh_nx[2:0]), .is_long(long_now));

   always_comb begin
      last_bit = bit_vld && ((cnt_q == CNT_SHORT && !long_q) || cnt_q == CNT_LONG);
      if (!long_q)
         idx_nx = IDX_W'({1'b0, sh_nx[CW_SHORT-1:0]}) - IDX_W'(2);
      else if (sh_nx[SH_W-1])
         idx_nx = IDX_W'(sh_nx) - IDX_W'(10);
      else
         idx_nx = IDX_W'(sh_nx) + IDX_W'(N_SHORT + N_HIGH);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q    <= '0;
         cnt_q   <= '0;
         long_q  <= 1'b0;
         idx_vld <= 1'b0;
         idx_out <= '0;
      end else begin
         idx_vld <= last_bit;
         if (last_bit) idx_out <= idx_nx;
         if (bit_vld) begin
            sh_q <= sh_nx;
            if (last_bit) begin
               cnt_q  <= '0;
               long_q <= 1'b0;
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
               if (cnt_q == CNT_HEAD) long_q <= long_now;
            end
         end
      end
   end

   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !bit_vld |=> $stable(cnt_q) && $stable(sh_q) && $stable(long_q));
   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CNT_LONG);
endmodule

// File: rtl/pfx_serial_enc.sv
module pfx_serial_enc
   import pfx_codec_pkg::*;
#(
   parameter int IDX_W = SYM_W,
   parameter int SH_W  = CW_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] sym_in,
   input  logic             sym_load,
   output logic             sym_ready,
   output logic             ser_out,
   output logic             ser_vld
);
   localparam int CNT_W = $clog2(SH_W + 1);

   logic [SH_W-1:0]  sh_q;
   logic [CNT_W-1:0] cnt_q;
   logic             take;
   cw_t              cw;

   always_comb begin
      cw        = cw_of(SYM_W'(sym_in));
      sym_ready = cnt_q <= CNT_W'(1);
      take      = sym_load && sym_ready && (sym_in < IDX_W'(LETTERS));
      ser_out   = sh_q[SH_W-1];
      ser_vld   = cnt_q != '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (take) begin
         sh_q  <= cw.long_cw ? cw.bits : {cw.bits[SH_W-2:0], 1'b0};
         cnt_q <= cw.long_cw ? CNT_W'(SH_W) : CNT_W'(CW_SHORT);
      end else if (cnt_q != '0) begin
         sh_q  <= {sh_q[SH_W-2:0], 1'b0};
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   p_reject_r9: assert property (@(posedge clk) disable iff (rst)
      sym_load && sym_in >= IDX_W'(LETTERS) && !ser_vld |=> !ser_vld);
   p_busy_r8: assert property (@(posedge clk) disable iff (rst)
      ser_vld && !sym_ready |=> ser_vld);
endmodule

// File: rtl/pfx_codec.sv
module pfx_codec
   import pfx_codec_pkg::*;
#(
   parameter int IDX_W = SYM_W,
   parameter int SH_W  = CW_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bit_in,
   input  logic             bit_vld,
   output logic [IDX_W-1:0] letter_out,
   output logic             letter_vld,
   input  logic [IDX_W-1:0] sym_in,
   input  logic             sym_load,
   output logic             sym_ready,
   output logic             ser_out,
   output logic             ser_vld
);
   generate
      if (IDX_W != SYM_W) begin : g_bad_idx
         $error("IDX_W must equal the package letter index width");
      end
      if (SH_W != CW_W) begin : g_bad_sh
         $error("SH_W must equal the longest codeword length");
      end
   endgenerate

   pfx_serial_dec #(.IDX_W(IDX_W), .SH_W(SH_W)) u_dec (
      .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
      .idx_out(letter_out), .idx_vld(letter_vld));

   pfx_serial_enc #(.IDX_W(IDX_W), .SH_W(SH_W)) u_enc (
      .clk(clk), .rst(rst), .sym_in(sym_in), .sym_load(sym_load),
      .sym_ready(sym_ready), .ser_out(ser_out), .ser_vld(ser_vld));

   p_reset_r1: assert property (@(posedge clk)
      rst |=> !letter_vld && !ser_vld && sym_ready);
   p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
      letter_vld |=> !letter_vld);
   p_range_r10: assert property (@(posedge clk) disable iff (rst)
      letter_vld |-> letter_out < IDX_W'(LETTERS));
endmodule

// File: tb/pfx_codec_test.sv
`timescale 1ns/1ps
module pfx_codec_test;
   localparam real HALF = 2.5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic drv_bit = 1'b0, drv_vld = 1'b0, loop_en = 1'b0;
   logic [4:0] sym_in = '0;
   logic sym_load = 1'b0;
   logic bit_in, bit_vld, letter_vld, sym_ready, ser_out, ser_vld;
   logic [4:0] letter_out;

   int n_vec = 0, n_bad = 0;
   int got_q[$];
   int ser_q[$];
   int cyc = 0, ser_n = 0, ser_first = 0, ser_last = 0;

   always #(HALF) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   assign bit_in  = loop_en ? ser_out : drv_bit;
   assign bit_vld = loop_en ? ser_vld : drv_vld;

   pfx_codec uut (
      .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
      .letter_out(letter_out), .letter_vld(letter_vld),
      .sym_in(sym_in), .sym_load(sym_load), .sym_ready(sym_ready),
      .ser_out(ser_out), .ser_vld(ser_vld));

   always @(negedge clk) begin
      if (letter_vld) got_q.push_back(int'(letter_out));
      if (ser_vld) begin
         ser_q.push_back(int'(ser_out));
         if (ser_n == 0) ser_first = cyc;
         ser_last = cyc;
         ser_n++;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int code_of(input int idx);
      if (idx < 6) return idx + 2;
      else if (idx < 22) return idx + 10;
      else return idx - 22;
   endfunction
   function automatic int len_of(input int idx);
      return (idx < 6) ? 4 : 5;
   endfunction

   task automatic send_letter(input int idx, input int stall);
      int c = code_of(idx);
      for (int i = len_of(idx) - 1; i >= 0; i--) begin
         for (int s = 0; s < stall; s++) begin
            @(negedge clk); drv_vld = 1'b0; drv_bit = ~drv_bit;
         end
         @(negedge clk); drv_vld = 1'b1; drv_bit = c[i];
      end
   endtask

   task automatic idle(input int n);
      @(negedge clk); drv_vld = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 letter_vld in reset", int'(letter_vld), 0);
      chk("R1 ser_vld in reset", int'(ser_vld), 0);
      chk("R1 sym_ready in reset", int'(sym_ready), 1);
      rst = 1'b0;
   endtask

   task automatic t_range(input int lo, input int hi, input string req);
      got_q.delete();
      for (int i = lo; i <= hi; i++) send_letter(i, 0);
      idle(3);
      chk({req, " count"}, got_q.size(), hi - lo + 1);
      for (int k = 0; k < got_q.size(); k++) chk(req, got_q[k], lo + k);
   endtask

   task automatic t_timing;   // R5
      got_q.delete();
      @(negedge clk); drv_vld = 1'b1; drv_bit = 1'b0;
      @(negedge clk); drv_bit = 1'b1;
      @(negedge clk); drv_bit = 1'b0;
      @(negedge clk); drv_bit = 1'b0;
      chk("R5 no early pulse", int'(letter_vld), 0);
      @(negedge clk);
      chk("R5 pulse after last bit", int'(letter_vld), 1);
      chk("R5 index c", int'(letter_out), 2);
      drv_bit = 1'b0;                 // z = 00011 back-to-back
      @(negedge clk);
      chk("R5 single-cycle pulse", int'(letter_vld), 0);
      drv_bit = 1'b0;
      @(negedge clk); drv_bit = 1'b0;
      @(negedge clk); drv_bit = 1'b1;
      @(negedge clk); drv_bit = 1'b1;
      @(negedge clk); drv_vld = 1'b0;
      chk("R5 back-to-back pulse", int'(letter_vld), 1);
      chk("R5 index z", int'(letter_out), 25);
      idle(2);
      chk("R5 pulse count", got_q.size(), 2);
   endtask

   task automatic t_stall;   // R6
      got_q.delete();
      send_letter(9, 2);
      send_letter(23, 3);
      send_letter(4, 1);
      idle(3);
      chk("R6 pulse count with stalls", got_q.size(), 3);
      if (got_q.size() == 3) begin
         chk("R6 first", got_q[0], 9);
         chk("R6 second", got_q[1], 23);
         chk("R6 third", got_q[2], 4);
      end
   endtask

   task automatic t_midreset;   // R1
      got_q.delete();
      @(negedge clk); drv_vld = 1'b1; drv_bit = 1'b1;
      @(negedge clk); drv_bit = 1'b0;
      @(negedge clk); drv_vld = 1'b0; rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      send_letter(0, 0);
      idle(2);
      chk("R1 realigned after reset count", got_q.size(), 1);
      if (got_q.size() == 1) chk("R1 realigned index", got_q[0], 0);
   endtask

   task automatic t_enc_one(input int idx);   // R7
      int v = 0;
      ser_q.delete();
      @(negedge clk); sym_in = 5'(idx); sym_load = 1'b1;
      @(negedge clk); sym_load = 1'b0;
      repeat (6) @(negedge clk);
      chk("R7 serial length", ser_q.size(), len_of(idx));
      foreach (ser_q[k]) v = (v << 1) | ser_q[k];
      chk("R7 serial code", v, code_of(idx));
   endtask

   task automatic t_loop;   // R8, R10
      got_q.delete();
      ser_n = 0;
      loop_en = 1'b1;
      for (int k = 0; k < 26; k++) begin
         @(negedge clk);
         while (!sym_ready) @(negedge clk);
         sym_in = 5'(k); sym_load = 1'b1;
      end
      @(negedge clk); sym_load = 1'b0;
      repeat (10) @(negedge clk);
      loop_en = 1'b0;
      chk("R8 total serial bits", ser_n, 124);
      chk("R8 gapless span", ser_last - ser_first + 1, 124);
      chk("R8 loopback count", got_q.size(), 26);
      for (int k = 0; k < got_q.size(); k++) chk("R10 loopback index", got_q[k], k);
   endtask

   task automatic t_reject(input int idx);   // R9
      ser_n = 0;
      @(negedge clk); sym_in = 5'(idx); sym_load = 1'b1;
      @(negedge clk); sym_load = 1'b0;
      chk("R9 no bits after bad index", int'(ser_vld), 0);
      chk("R9 still ready", int'(sym_ready), 1);
      repeat (4) @(negedge clk);
      chk("R9 no serial cycles", ser_n, 0);
   endtask

   initial begin
      t_reset();
      t_range(0, 5, "R2");
      t_range(6, 21, "R3");
      t_range(22, 25, "R4");
      t_timing();
      t_stall();
      t_midreset();
      t_enc_one(13);
      t_enc_one(1);
      t_enc_one(24);
      t_loop();
      t_reject(27);
      t_reject(31);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(HALF * 2 * 150000);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule